// File: doc/BRIEF.md
# Bit-Serial Program Counter

This block holds a 16-bit program counter that is rewritten one bit at a time. Its value is presented in parallel as the address of a 64K-word program store. Each machine cycle is opened by a start pulse that also samples the jump select. It is then completed by sixteen shift enables. On each enable, the least significant bit of the register is replaced at the top by either the incremented bit or a bit of the jump target.

The increment uses one half adder and a single carry flop. The carry is preset to one when the cycle opens, so the stored value gains one at its lowest bit, and the carry ripples upward across the sixteen steps. A jump instead takes its bits LSB first from a serial stream, normally fed from an 8-bit register. Bit positions at or above the jump source width (`JUMP_BITS`) are filled with zero. The address is only meaningful while `addr_valid` is high, which means that no update is in progress.

Top module: `serial_pc`

## Requirements
- R1: After a synchronous active-low reset, `pc_addr` is 0x0000 and `addr_valid` is 1.
- R2: A `cycle_start` pulse while `addr_valid` is 1 makes `addr_valid` 0 from the next clock edge. `jump_sel` is sampled at that same edge: 1 selects a jump and 0 selects an increment.
- R3: A cycle completes on exactly the 16th clock edge with `shift_en` high after the start. Cycles with `shift_en` low do not count. After 15 enables `addr_valid` is still 0, and after the 16th it is 1.
- R4: An increment cycle leaves `pc_addr` equal to the previous value plus one, modulo 2^16, so 0xFFFF becomes 0x0000.
- R5: A jump cycle takes `jump_bit` on the k-th counted enable (k = 0..15) as bit k of the new address when k < `JUMP_BITS`; all higher bits become 0.
- R6: After k counted enables of a cycle, `pc_addr` holds the old value shifted right by k, with the k lowest bits of the new value in its top k positions. The new bit always enters at bit 15.
- R7: While `addr_valid` is 1, `shift_en` and `jump_bit` have no effect and `pc_addr` is held.
- R8: While `addr_valid` is 0, `cycle_start` and changes of `jump_sel` are ignored. The cycle in progress ends with the result chosen at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cycle_start | input | 1 | Opens a machine cycle when idle |
| shift_en | input | 1 | One serial step per high cycle during an update |
| jump_sel | input | 1 | Sampled at start: 1 = jump, 0 = increment |
| jump_bit | input | 1 | Serial jump target, LSB first |
| pc_addr | output | 16 | Parallel program address |
| addr_valid | output | 1 | High when no update is in progress |

## Verification
`addr_valid` falls one edge after an accepted start. The register moves one position on each edge with `shift_en` high. The final address and the return of `addr_valid` both appear on the edge of the 16th enable. The bench keeps a behavioural model that advances on the same edges from the same inputs. It compares both outputs at every falling edge, after all registers of that edge have settled. Named checks are placed at the falling edges after the start, after the 15th enable and after the 16th enable. Two instances run side by side, one with an 8-bit jump width and one with a 16-bit jump width. The wide one can reach 0xFFFF, so the rollover case is exercised as well as zero fill.

// File: rtl/serial_pc_pkg.sv
// Shared types for the bit-serial program counter.
package serial_pc_pkg;
    // Source of the bit written into the top of the register on each step.
    typedef enum logic {
        PC_SRC_INC  = 1'b0,
        PC_SRC_JUMP = 1'b1
    } pc_src_e;
endpackage

// File: rtl/serial_pc_seq.sv
// Step sequencer: accepts a cycle start when idle, latches the source
// selection, and counts shift enables until PC_W steps are done.
// Assumes cycle_start and shift_en are synchronous to clk.
module serial_pc_seq
    import serial_pc_pkg::*;
#(
    parameter int PC_W  = 16,
    localparam int CNT_W = $clog2(PC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_start,
    input  logic             shift_en,
    input  logic             jump_sel,
    output logic             busy,
    output logic             start_acc,
    output logic             step,
    output logic [CNT_W-1:0] bit_idx,
    output pc_src_e          src
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PC_W - 1);

    // Accept a start only when idle; count steps only when busy.
    always_comb begin
        start_acc = cycle_start & ~busy;
        step      = shift_en & busy;
    end

    // Busy flag, step index and latched source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bit_idx <= '0;
            src     <= PC_SRC_INC;
        end else if (start_acc) begin
            busy    <= 1'b1;
            bit_idx <= '0;
            src     <= jump_sel ? PC_SRC_JUMP : PC_SRC_INC;
        end else if (step) begin
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == LAST_IDX) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/serial_pc_bitalu.sv
// Serial bit unit: a half adder with a one-bit carry store, and a 2:1
// multiplexer choosing the incremented bit or the (zero-filled) jump bit.
// Assumes start_acc and step are never high together.
module serial_pc_bitalu
    import serial_pc_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int JUMP_BITS = 8,
    localparam int CNT_W    = $clog2(PC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_acc,
    input  logic             step,
    input  pc_src_e          src,
    input  logic [CNT_W-1:0] bit_idx,
    input  logic             cur_lsb,
    input  logic             jump_bit,
    output logic             new_bit
);
    logic carry_q;
    logic jump_gated;

    // Carry store: preset to one at cycle start, then keeps the half-adder carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (start_acc) begin
            carry_q <= 1'b1;
        end else if (step) begin
            carry_q <= cur_lsb & carry_q;
        end
    end

    // Jump bit: passed through for every position, or zeroed above the source width.
    generate
        if (JUMP_BITS >= PC_W) begin : g_full_jump
            always_comb jump_gated = jump_bit;
        end else begin : g_part_jump
            localparam logic [CNT_W-1:0] JUMP_LIM = CNT_W'(JUMP_BITS);
            always_comb jump_gated = (bit_idx < JUMP_LIM) ? jump_bit : 1'b0;
        end
    endgenerate

    // Output multiplexer: half-adder sum or jump bit.
    always_comb begin
        new_bit = (src == PC_SRC_JUMP) ? jump_gated : (cur_lsb ^ carry_q);
    end
endmodule

// File: rtl/serial_pc_shreg.sv
// Right-shifting register holding the counter: the LSB leaves on each step
// and the new bit enters at the top. Its parallel outputs form the address.
module serial_pc_shreg #(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            new_bit,
    output logic [PC_W-1:0] q
);
    // Shift right by one on each step; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (step) begin
            q <= {new_bit, q[PC_W-1:1]};
        end
    end
endmodule

// File: rtl/serial_pc.sv
// Bit-serial program counter top. Each machine cycle either adds one or
// loads a serial jump target over PC_W shift enables. The address is
// meaningful only while addr_valid is high.
module serial_pc
    import serial_pc_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int JUMP_BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cycle_start,
    input  logic            shift_en,
    input  logic            jump_sel,
    input  logic            jump_bit,
    output logic [PC_W-1:0] pc_addr,
    output logic            addr_valid
);
    localparam int CNT_W = $clog2(PC_W);

    logic             busy;
    logic             start_acc;
    logic             step;
    logic [CNT_W-1:0] bit_idx;
    pc_src_e          src;
    logic             new_bit;
    logic [PC_W-1:0]  pc_q;

    serial_pc_seq #(.PC_W(PC_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_start (cycle_start),
        .shift_en    (shift_en),
        .jump_sel    (jump_sel),
        .busy        (busy),
        .start_acc   (start_acc),
        .step        (step),
        .bit_idx     (bit_idx),
        .src         (src)
    );

    serial_pc_bitalu #(.PC_W(PC_W), .JUMP_BITS(JUMP_BITS)) u_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (start_acc),
        .step      (step),
        .src       (src),
        .bit_idx   (bit_idx),
        .cur_lsb   (pc_q[0]),
        .jump_bit  (jump_bit),
        .new_bit   (new_bit)
    );

    serial_pc_shreg #(.PC_W(PC_W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .new_bit (new_bit),
        .q       (pc_q)
    );

    // Outputs: parallel register contents and idle indication.
    always_comb begin
        pc_addr    = pc_q;
        addr_valid = ~busy;
    end
endmodule

// File: rtl/serial_pc_chk.sv
// Port-level checker for serial_pc: tracks each accepted cycle with its own
// step counter, start value and mode, and checks results at completion.
module serial_pc_chk #(
    parameter int PC_W      = 16,
    parameter int JUMP_BITS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cycle_start,
    input logic            shift_en,
    input logic            jump_sel,
    input logic            jump_bit,
    input logic [PC_W-1:0] pc_addr,
    input logic            addr_valid
);
    localparam int SC_W = $clog2(PC_W + 1);

    logic [SC_W-1:0] steps_seen;
    logic [PC_W-1:0] base_val;
    logic [PC_W-1:0] base_plus;
    logic            jump_mode;
    logic            unused_in;

    always_comb base_plus = base_val + 1'b1;
    always_comb unused_in = jump_bit;

    // Record the start of each accepted cycle and count its steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steps_seen <= '0;
            base_val   <= '0;
            jump_mode  <= 1'b0;
        end else if (cycle_start && addr_valid) begin
            steps_seen <= '0;
            base_val   <= pc_addr;
            jump_mode  <= jump_sel;
        end else if (!addr_valid && shift_en) begin
            steps_seen <= steps_seen + 1'b1;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc_addr == '0) && addr_valid);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && addr_valid) |=> !addr_valid);

    assert_cycle_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid) |-> (steps_seen == SC_W'(PC_W)));

    assert_increment_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(addr_valid) && !jump_mode) |-> (pc_addr == base_plus));

    assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(addr_valid) && jump_mode) |-> ((pc_addr >> JUMP_BITS) == '0));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> $stable(pc_addr));
endmodule

bind serial_pc serial_pc_chk #(.PC_W(PC_W), .JUMP_BITS(JUMP_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_start (cycle_start),
    .shift_en    (shift_en),
    .jump_sel    (jump_sel),
    .jump_bit    (jump_bit),
    .pc_addr     (pc_addr),
    .addr_valid  (addr_valid)
);

// File: tb/serial_pc_bench.sv
// Bench: two instances (8-bit and 16-bit jump source) against a behavioural model.
module serial_pc_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cycle_start = 1'b0;
    logic        shift_en = 1'b0;
    logic        jump_sel = 1'b0;
    logic        jump_bit = 1'b0;
    logic [15:0] addr_n, addr_w;
    logic        valid_n, valid_w;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit started = 0;
    int jword = 0;

    // model state: index 0 = narrow (8-bit jump), 1 = wide (16-bit jump)
    int m_pc[2];
    int m_old[2];
    int m_tgt[2];
    int m_mask[2] = '{32'h00FF, 32'hFFFF};
    bit m_busy = 0;
    int m_k = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_pc u_serial_pc (
        .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .shift_en(shift_en),
        .jump_sel(jump_sel), .jump_bit(jump_bit), .pc_addr(addr_n), .addr_valid(valid_n)
    );

    serial_pc #(.JUMP_BITS(16)) u_serial_pc_wide (
        .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .shift_en(shift_en),
        .jump_sel(jump_sel), .jump_bit(jump_bit), .pc_addr(addr_w), .addr_valid(valid_w)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Behavioural model, advanced on the same edges from the same inputs.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_busy = 0; m_k = 0;
            for (int d = 0; d < 2; d++) m_pc[d] = 0;
        end else if (!m_busy && cycle_start) begin
            m_busy = 1; m_k = 0;
            for (int d = 0; d < 2; d++) begin
                m_old[d] = m_pc[d];
                m_tgt[d] = jump_sel ? (jword & m_mask[d]) : ((m_pc[d] + 1) & 32'hFFFF);
            end
        end else if (m_busy && shift_en) begin
            m_k++;
            for (int d = 0; d < 2; d++)
                m_pc[d] = (m_old[d] >> m_k) | ((m_tgt[d] & ((1 << m_k) - 1)) << (16 - m_k));
            if (m_k == 16) m_busy = 0;
        end
    end

    // Every falling edge: compare both instances with the model (R6, R1).
    always @(negedge clk) begin
        if (started && !done) begin
            chk(addr_n == 16'(m_pc[0]), "R6 narrow addr", int'(addr_n), m_pc[0]);
            chk(addr_w == 16'(m_pc[1]), "R6 wide addr", int'(addr_w), m_pc[1]);
            chk(valid_n == !m_busy && valid_w == !m_busy, "R6 valid",
                int'({valid_n, valid_w}), int'({!m_busy, !m_busy}));
        end
    end

    // One machine cycle; gap inserts idle cycles between enables,
    // inj_at >= 0 pulses cycle_start with jump_sel=1 after that many enables.
    task automatic run_cycle(input bit jmp, input int jw, input bit gap, input int inj_at,
                             input int exp_n, input int exp_w);
        @(negedge clk);
        jword = jw; jump_sel = jmp; cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0; jump_sel = 1'b0;
        chk(!valid_n && !valid_w, "R2 busy after start", int'(valid_n), 0);
        for (int i = 0; i < 16; i++) begin
            if (i == 15) chk(!valid_n && !valid_w, "R3 busy after 15 enables", int'(valid_n), 0);
            if (i == inj_at) begin cycle_start = 1'b1; jump_sel = 1'b1; end
            shift_en = 1'b1; jump_bit = jw[i];
            @(negedge clk);
            cycle_start = 1'b0; jump_sel = 1'b0;
            if (gap) begin
                shift_en = 1'b0; jump_bit = ~jump_bit;
                @(negedge clk);
            end
        end
        shift_en = 1'b0;
        chk(valid_n && valid_w, "R3 done after 16 enables", int'(valid_n), 1);
        chk(addr_n == 16'(exp_n), jmp ? "R5 narrow result" : "R4 narrow result", int'(addr_n), exp_n);
        chk(addr_w == 16'(exp_w), jmp ? "R5 wide result" : "R4 wide result", int'(addr_w), exp_w);
    endtask

    task automatic idle_shifts(input int n);
        logic [15:0] hold_n, hold_w;
        hold_n = addr_n; hold_w = addr_w;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            shift_en = 1'b1; jump_bit = i[0];
        end
        @(negedge clk);
        shift_en = 1'b0;
        chk(addr_n == hold_n && addr_w == hold_w, "R7 idle shifts ignored", int'(addr_n), int'(hold_n));
    endtask

    task automatic finish_run;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(addr_n == 0 && addr_w == 0 && valid_n && valid_w, "R1 reset state", int'(addr_n), 0);
        idle_shifts(3);
        run_cycle(0, 0, 0, -1, 16'h0001, 16'h0001);
        run_cycle(0, 16'hFFFF, 1, -1, 16'h0002, 16'h0002);
        run_cycle(0, 0, 0, -1, 16'h0003, 16'h0003);
        run_cycle(1, 16'hAB12, 0, -1, 16'h0012, 16'hAB12);
        run_cycle(0, 0, 1, -1, 16'h0013, 16'hAB13);
        // R8: start pulse with jump_sel mid-cycle is ignored
        run_cycle(0, 16'h5A5A, 0, 5, 16'h0014, 16'hAB14);
        run_cycle(1, 16'hFFFF, 1, -1, 16'h00FF, 16'hFFFF);
        // R4: rollover 0xFFFF -> 0x0000 on the wide instance
        run_cycle(0, 0, 0, -1, 16'h0100, 16'h0000);
        idle_shifts(4);
        run_cycle(1, 16'h00C3, 0, -1, 16'h00C3, 16'h00C3);
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule